// File: doc/BRIEF.md
# Burst-Correcting Shortened Cyclic Code Encoder (Transmit Side)

This block is the transmit half of a light forward error correction layer for a 64b/66b link. It adds coding without raising the line rate, because each 2-bit sync header is reduced to a single transcode bit and the bits saved make room for the check bits. The block accepts one 66-bit block each time it is ready and turns the block into a 65-bit word. Once it has 32 such words (2080 message bits), it appends 32 parity bits from a systematic division by a degree-32 generator polynomial. That gives a 2112-bit codeword, and the receiver can use the code to correct a single burst of up to 11 bits.

Every bit of the codeword leaves the block serially, one bit per clock. Each bit is first XORed with a pseudo-noise sequence from a 58-stage generator, and that generator is reloaded with a fixed seed at the start of every codeword. The scrambling keeps the line DC balanced. It also ensures that no shifted alignment of the stream looks like a valid codeword, which the receiver's block lock depends on. The upstream source offers a block when `in_ready` is high. While a word or the parity is being sent, any block offered is ignored.

Top module: `fecb_encoder`

## Requirements
- R1: While reset is high and in the cycle after it falls, `in_ready` is 1 and `out_valid` is 0.
- R2: `in_ready` is high exactly when no codeword bit is being emitted. A block presented with `in_valid` while `in_ready` is low is ignored and leaves the output stream unchanged.
- R3: An accepted block is emitted as a 65-bit word. The transcode bit comes first and equals `in_blk[65]`, so header `{in_blk[65],in_blk[64]}` = 2'b01 gives 0 and 2'b10 gives 1. After it come payload bits `in_blk[0]` through `in_blk[63]` in that order. All bits appear before scrambling is applied.
- R4: The 32 bits after the 2080 message bits are the remainder of message·x^32 divided by g(x) = x^32+x^23+x^21+x^11+x^2+1, highest power first. The message is the first transmitted bit taken as the highest power. The unscrambled 2112-bit codeword is a multiple of g(x).
- R5: Output bit n of a codeword (n = 0..2111) is the codeword bit XOR p[n]. Here p[n] = h[n] XOR h[n+19], with h[n+58] = p[n], and the initial history h[0..57] = 1,0,1,0,…,1,0 (h[i] = 1 for even i).
- R6: The scrambling sequence restarts for every codeword, so two codewords built from identical blocks are emitted identically.
- R7: After the 32nd accepted block of a codeword, the block emits the 32 parity bits back to back with `in_ready` low. Every codeword is exactly 2112 output bits.
- R8: After a block is accepted, `out_valid` stays high for exactly 65 consecutive cycles starting in the next cycle. After the 32nd block of a codeword it stays high for 97 cycles.
- R9: A reset in the middle of a codeword discards the partial codeword. The next accepted block starts a new codeword from word 0 with cleared parity and a reseeded scrambler.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A 66-bit block is offered on `in_blk` |
| in_blk | input | 66 | Bits 65:64 sync header, bits 63:0 payload |
| in_ready | output | 1 | Block waits for the next input block |
| out_valid | output | 1 | `out_bit` carries a codeword bit this cycle |
| out_bit | output | 1 | Scrambled serial codeword bit |

## Verification
The bound checker enforces the word rhythm on every cycle. An accepted block must start emission in the next cycle. Each burst of `out_valid` must last 65 or 97 cycles. Each codeword must close only after 32 accepted blocks, and the parity register and scrambler must return to their start state right after that. The bit values themselves can only be judged by the bench's scenarios, which compare every output bit with a model built by long division and a scrambler recurrence. These scenarios include the scrambler seen alone under an all-zero message, an 11-bit burst payload, blocks offered while the block is busy, a repeated codeword, and a reset in the middle of a codeword.

// File: rtl/fecb_pkg.sv
package fecb_pkg;

  // parity width is fixed by the generator polynomial
  localparam int P_BITS = 32;
  // x^23 + x^21 + x^11 + x^2 + 1 (x^32 is implicit)
  localparam logic [P_BITS-1:0] GEN_TAPS = 32'h00A0_0805;

  // scrambler: x^58 + x^39 + 1, seed alternates starting with 1 at the top stage
  localparam int PN_W = 58;
  localparam int PN_TAP = 38;
  localparam logic [PN_W-1:0] PN_SEED = 58'h2AA_AAAA_AAAA_AAAA;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_MSG  = 2'd1,
    ST_PAR  = 2'd2
  } enc_st_t;

  // one message bit into the systematic division register
  function automatic logic [P_BITS-1:0] par_absorb(input logic [P_BITS-1:0] r, input logic b);
    logic fb;
    fb = b ^ r[P_BITS-1];
    return {r[P_BITS-2:0], 1'b0} ^ ({P_BITS{fb}} & GEN_TAPS);
  endfunction

  // current scrambler output bit
  function automatic logic pn_out(input logic [PN_W-1:0] s);
    return s[PN_W-1] ^ s[PN_TAP];
  endfunction

  // scrambler advance by one bit
  function automatic logic [PN_W-1:0] pn_next(input logic [PN_W-1:0] s);
    return {s[PN_W-2:0], pn_out(s)};
  endfunction

endpackage

// File: rtl/fecb_ctl.sv
module fecb_ctl
  import fecb_pkg::*;
#(
  parameter int WORDS  = 32,
  parameter int WORD_W = 65
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    accept,
  output enc_st_t st,
  output logic    cw_end
);

  localparam int SPAN  = (WORD_W > P_BITS) ? WORD_W : P_BITS;
  localparam int BCW   = $clog2(SPAN);
  localparam int WCW   = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [BCW-1:0] bcnt;
  logic [WCW-1:0] wcnt;
  logic word_last_bit;
  logic last_word;

  assign word_last_bit = (bcnt == BCW'(WORD_W - 1));
  assign last_word     = (wcnt == WCW'(WORDS - 1));
  assign cw_end        = (st == ST_PAR) && (bcnt == BCW'(P_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_WAIT;
      bcnt <= '0;
      wcnt <= '0;
    end else begin
      unique case (st)
        ST_WAIT: begin
          if (accept) begin
            st   <= ST_MSG;
            bcnt <= '0;
          end
        end
        ST_MSG: begin
          if (word_last_bit) begin
            bcnt <= '0;
            if (last_word) begin
              wcnt <= '0;
              st   <= ST_PAR;
            end else begin
              wcnt <= wcnt + 1'b1;
              st   <= ST_WAIT;
            end
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (cw_end) begin
            bcnt <= '0;
            st   <= ST_WAIT;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        default: st <= ST_WAIT;
      endcase
    end
  end

endmodule

// File: rtl/fecb_parity_lfsr.sv
module fecb_parity_lfsr
  import fecb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              absorb,
  input  logic              drain,
  input  logic              din,
  output logic              par_msb,
  output logic [P_BITS-1:0] par_q
);

  logic [P_BITS-1:0] r;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      r <= '0;
    end else if (absorb) begin
      r <= par_absorb(r, din);
    end else if (drain) begin
      r <= {r[P_BITS-2:0], 1'b0};
    end
  end

  assign par_msb = r[P_BITS-1];
  assign par_q   = r;

endmodule

// File: rtl/fecb_pn_gen.sv
module fecb_pn_gen
  import fecb_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            adv,
  output logic            pn_bit,
  output logic [PN_W-1:0] pn_q
);

  logic [PN_W-1:0] s;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      s <= PN_SEED;
    end else if (adv) begin
      s <= pn_next(s);
    end
  end

  assign pn_bit = pn_out(s);
  assign pn_q   = s;

endmodule

// File: rtl/fecb_encoder.sv
module fecb_encoder
  import fecb_pkg::*;
#(
  parameter int WORDS = 32,
  parameter int PAY_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [PAY_W+1:0] in_blk,
  output logic             in_ready,
  output logic             out_valid,
  output logic             out_bit
);

  localparam int WORD_W = PAY_W + 1;

  enc_st_t           st;
  logic              cw_end;
  logic              accept;
  logic              in_msg;
  logic              in_par;
  logic [WORD_W-1:0] word_sh;
  logic              msg_bit;
  logic              par_msb;
  logic              pn_bit;
  logic [P_BITS-1:0] par_state;
  logic [PN_W-1:0]   pn_state;

  assign in_ready  = (st == ST_WAIT);
  assign accept    = in_valid && in_ready;
  assign in_msg    = (st == ST_MSG);
  assign in_par    = (st == ST_PAR);
  assign out_valid = in_msg || in_par;

  fecb_ctl #(
    .WORDS (WORDS),
    .WORD_W(WORD_W)
  ) u_ctl (
    .clk   (clk),
    .rst   (rst),
    .accept(accept),
    .st    (st),
    .cw_end(cw_end)
  );

  // word shifter: bit 0 is the transcode bit, then payload LSB first
  always_ff @(posedge clk) begin
    if (rst) begin
      word_sh <= '0;
    end else if (accept) begin
      word_sh <= {in_blk[PAY_W-1:0], in_blk[PAY_W+1]};
    end else if (in_msg) begin
      word_sh <= {1'b0, word_sh[WORD_W-1:1]};
    end
  end

  assign msg_bit = word_sh[0];

  fecb_parity_lfsr u_par (
    .clk    (clk),
    .rst    (rst),
    .clr    (cw_end),
    .absorb (in_msg),
    .drain  (in_par),
    .din    (msg_bit),
    .par_msb(par_msb),
    .par_q  (par_state)
  );

  fecb_pn_gen u_pn (
    .clk    (clk),
    .rst    (rst),
    .restart(cw_end),
    .adv    (out_valid),
    .pn_bit (pn_bit),
    .pn_q   (pn_state)
  );

  assign out_bit = (in_msg ? msg_bit : par_msb) ^ pn_bit;

endmodule

// File: rtl/fecb_checker.sv
module fecb_checker
  import fecb_pkg::*;
#(
  parameter int WORDS  = 32,
  parameter int WORD_W = 65
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              cw_end,
  input logic [P_BITS-1:0] par_state,
  input logic [PN_W-1:0]   pn_state
);

  logic [15:0] run;
  logic [15:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= '0;
    end else if (out_valid) begin
      run <= run + 1'b1;
    end else begin
      run <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cw_end) begin
      acc <= '0;
    end else if (in_valid && in_ready) begin
      acc <= acc + 1'b1;
    end
  end

  // R1: idle state right after reset
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_ready && !out_valid));

  // R2: an accepted block closes the input and opens emission
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && !in_ready));

  // R8: each emission burst is one word or one word plus parity
  assert_burst_len_R8: assert property (@(posedge clk) disable iff (rst)
    ($fell(out_valid) && !$past(rst)) |->
      (run == 16'(WORD_W) || run == 16'(WORD_W + P_BITS)));

  // R7: a codeword closes only after all of its blocks were taken
  assert_word_count_R7: assert property (@(posedge clk) disable iff (rst)
    cw_end |-> (acc == 16'(WORDS)));

  // R6: division register and scrambler return to start state per codeword
  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    cw_end |=> (pn_state == PN_SEED && par_state == '0));

endmodule

bind fecb_encoder fecb_checker #(
  .WORDS (WORDS),
  .WORD_W(WORD_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .cw_end   (cw_end),
  .par_state(par_state),
  .pn_state (pn_state)
);

// File: tb/fecb_encoder_tb.sv
module fecb_encoder_tb;

  localparam int WORDS  = 32;
  localparam int PAY_W  = 64;
  localparam int WORD_W = PAY_W + 1;
  localparam int MSG_N  = WORDS * WORD_W;
  localparam int CW_N   = MSG_N + 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [PAY_W+1:0] in_blk = '0;
  logic in_ready;
  logic out_valid;
  logic out_bit;

  always #5 clk = ~clk;

  fecb_encoder #(.WORDS(WORDS), .PAY_W(PAY_W)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_blk   (in_blk),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_bit  (out_bit)
  );

  int checks = 0;
  int errors = 0;
  int bits_seen = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  bit exp_q[$];
  string tag_q[$];
  logic [PAY_W+1:0] blks [0:WORDS-1];
  bit pn_seq [0:CW_N-1];
  logic [63:0] xs = 64'h9E37_79B9_7F4A_7C15;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // R5 model: recurrence over a history list, oldest bit first
  task automatic build_pn();
    bit h [0:CW_N+57];
    for (int i = 0; i < 58; i++) h[i] = (i % 2 == 0);
    for (int n = 0; n < CW_N; n++) begin
      h[n+58] = h[n] ^ h[n+19];
      pn_seq[n] = h[n+58];
    end
  endtask

  // R4 model: long division by g(x); remainder bit 31 is the first parity bit
  function automatic logic [31:0] rem_of(input bit a [0:CW_N-1]);
    bit d [0:CW_N-1];
    logic [31:0] r;
    d = a;
    for (int i = 0; i < MSG_N; i++) begin
      if (d[i]) begin
        d[i]    = ~d[i];
        d[i+9]  = ~d[i+9];
        d[i+11] = ~d[i+11];
        d[i+21] = ~d[i+21];
        d[i+30] = ~d[i+30];
        d[i+32] = ~d[i+32];
      end
    end
    for (int k = 0; k < 32; k++) r[31-k] = d[MSG_N+k];
    return r;
  endfunction

  function automatic logic [63:0] next_rand();
    xs = xs ^ (xs << 13);
    xs = xs ^ (xs >> 7);
    xs = xs ^ (xs << 17);
    return xs;
  endfunction

  // 0: all-zero payload, header 01; 1: pseudo-random with mixed headers; 2: one 11-bit burst
  task automatic make_blocks(input int mode);
    for (int w = 0; w < WORDS; w++) begin
      logic [63:0] p;
      case (mode)
        0: blks[w] = {2'b01, 64'h0};
        1: begin
          p = next_rand();
          blks[w] = {p[0] ? 2'b10 : 2'b01, p};
        end
        default: blks[w] = {2'b10, (w == 7) ? 64'h0000_0000_0003_FF80 : 64'h0};
      endcase
    end
  endtask

  // scoreboard driver: push the expected scrambled codeword, then offer the blocks
  task automatic send_cw(input int nw, input bit push, input bit inject, input string kind);
    bit m [0:CW_N-1];
    logic [31:0] rem;
    if (push) begin
      for (int n = 0; n < CW_N; n++) m[n] = 1'b0;
      for (int w = 0; w < WORDS; w++) begin
        m[w*WORD_W] = blks[w][PAY_W+1];
        for (int j = 0; j < PAY_W; j++) m[w*WORD_W+1+j] = blks[w][j];
      end
      rem = rem_of(m);
      for (int n = 0; n < CW_N; n++) begin
        bit e;
        string t;
        e = ((n < MSG_N) ? m[n] : rem[31-(n-MSG_N)]) ^ pn_seq[n];
        if (kind.len() > 0) t = kind;
        else if (n >= MSG_N) t = "R4 parity bit";
        else if (n % WORD_W == 0) t = "R3 transcode bit";
        else t = "R3 payload bit";
        exp_q.push_back(e);
        tag_q.push_back($sformatf("%s at %0d", t, n));
      end
    end
    for (int w = 0; w < nw; w++) begin
      @(negedge clk);
      while (!in_ready) begin
        // R2: offers made while busy must be dropped
        in_valid = inject;
        in_blk   = {2'b10, 64'hDEAD_BEEF_F00D_CAFE};
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_blk   = blks[w];
      @(negedge clk);
      in_valid = 1'b0;
      in_blk   = '0;
    end
  endtask

  // scoreboard monitor
  int pos = 0;
  int run = 0;
  bit prev_v = 1'b0;
  bit rx [0:CW_N-1];

  always @(negedge clk) begin
    if (rst) begin
      pos = 0;
      run = 0;
      prev_v = 1'b0;
    end else if (mon_en) begin
      if (out_valid && in_ready)
        check(1'b0, "R2 in_ready high during emission", 1, 0);
      if (out_valid) begin
        run++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 bit beyond codeword", 1, 0);
        end else begin
          bit e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_bit == e, t, out_bit, e);
        end
        bits_seen++;
        rx[pos] = out_bit;
        pos++;
        if (pos == CW_N) begin
          bit d [0:CW_N-1];
          logic [31:0] r;
          for (int n = 0; n < CW_N; n++) d[n] = rx[n] ^ pn_seq[n];
          r = rem_of(d);
          check(r == 32'h0, "R4 descrambled codeword not a multiple of g", r, 0);
          pos = 0;
        end
      end else if (prev_v) begin
        // R8: burst lengths
        check(run == WORD_W || run == WORD_W + 32, "R8 out_valid burst length", run, WORD_W);
        run = 0;
      end
      prev_v = out_valid;
    end
  end

  initial begin
    build_pn();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1 state during reset", {in_ready, out_valid}, 2'b10);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1 state after reset", {in_ready, out_valid}, 2'b10);
    mon_en = 1'b1;

    // R5: all-zero message, the stream is the scrambler sequence alone
    make_blocks(0);
    send_cw(WORDS, 1'b1, 1'b0, "R5 zero message");
    // R3 R4: random payloads and mixed headers
    make_blocks(1);
    send_cw(WORDS, 1'b1, 1'b0, "");
    // R2: busy offers on every idle wait, with an 11-bit burst payload
    make_blocks(2);
    send_cw(WORDS, 1'b1, 1'b1, "R2 busy offers ignored");
    // R6: the same blocks again must give the same stream
    send_cw(WORDS, 1'b1, 1'b0, "R6 repeated codeword");

    // R9: partial codeword then reset
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    mon_en = 1'b0;
    make_blocks(1);
    send_cw(3, 1'b0, 1'b0, "");
    repeat (20) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R9 idle after mid-codeword reset", {in_ready, out_valid}, 2'b10);
    mon_en = 1'b1;
    send_cw(WORDS, 1'b1, 1'b0, "R9 fresh codeword after reset");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R7 idle after last parity bit", {in_ready, out_valid}, 2'b10);
    check(bits_seen == 5 * CW_N, "R7 total emitted bits", bits_seen, 5 * CW_N);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule